// File: doc/BRIEF.md
# Masked ASID-Tagged Translation Buffer

This block is a small, fully associative address translation buffer. Each slot holds a tag for a pair of adjacent virtual pages and two physical frame numbers, one for the even page and one for the odd page. Each frame has its own attribute, dirty and valid bits. A slot also holds a page-size mask, an address-space identifier and a global flag. These three are shared by both frames. The mask widens the page pair: tag bits under set mask bits are ignored, so a single slot can cover a larger region.

Every cycle the block serves four things at once:
- a combinational lookup of a full virtual address, returning hit, invalid-frame miss, slot index and frame data;
- a probe of a bare page-pair number that returns the first matching slot, or an all-ones code when nothing matches;
- a write of a whole slot by index;
- a read of a slot, chosen either by an explicit index or by an internal next-to-use pointer that can be advanced.

A flush input, and the synchronous reset, clear the whole table and the pointer. Any access whose address carries the uncacheable pattern is flagged, whatever the translation result.

Top module: `masked_tlb`

## Requirements
- R1: A slot matches a lookup or probe when the page-pair number (address bits 31:13) equals the stored tag in every bit whose mask bit is 0. Mask bit k covers page-pair bit k for k below 16; the upper three tag bits are always compared.
- R2: A tag match counts only if the slot's global flag is set or the request identifier equals the stored identifier.
- R3: A write whose index is 16 or more (at or beyond ENTRIES) leaves every slot unchanged, and wr_overflow is 1 in that cycle. It is 0 otherwise.
- R4: pr_slot gives the lowest matching slot index, zero-extended, or all ones (5'h1F by default) when no slot matches.
- R5: The frame is chosen by address bit 12+p, where p is the count of trailing ones in the slot's mask: 1 selects the odd frame and 0 the even frame. If the chosen frame's valid bit is 0, lk_invalid is 1, lk_hit is 0, and the frame outputs read zero. On a plain miss, lk_hit, lk_invalid, lk_index and the frame outputs are all zero.
- R6: When several slots match, the lowest index wins.
- R7: Reset, or flush at a clock edge, zeroes every field of every slot and sets the next-to-use pointer to 0. Flush takes priority over a write or an advance in the same cycle.
- R8: lk_uncached is 1 exactly when address bits 31 and 29 are both 1. This is independent of hit or miss.
- R9: Slot layout on wr_entry and rd_entry: [93:75] tag, [74:59] mask, [58:51] identifier, [50] global, [49:30] odd frame, [29:27] odd attribute, [26] odd dirty, [25] odd valid, [24:5] even frame, [4:2] even attribute, [1] even dirty, [0] even valid. rd_slot is the next-to-use pointer when rd_use_next is 1, else rd_index, and rd_entry is that slot. rd_advance increments the pointer at the edge, wrapping from ENTRIES-1 to 0.
- R10: Writes take effect at the clock edge. A lookup or probe in the same cycle as a write to the same slot sees the old contents.
- R11: A slot with both frame valid bits at 0 never matches a lookup or probe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Clear whole table and pointer at the edge |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_asid | input | 8 | Lookup address-space identifier |
| lk_hit | output | 1 | Lookup matched a slot with a valid selected frame |
| lk_invalid | output | 1 | Lookup matched but the selected frame is invalid |
| lk_index | output | 4 | Matching slot index, zero on miss |
| lk_pfn | output | 20 | Physical frame number on hit |
| lk_attr | output | 3 | Cache attribute of the frame on hit |
| lk_dirty | output | 1 | Dirty bit of the frame on hit |
| lk_uncached | output | 1 | Address carries the uncacheable pattern |
| pr_vpn2 | input | 19 | Probe page-pair number |
| pr_asid | input | 8 | Probe address-space identifier |
| pr_slot | output | 5 | Lowest matching slot, all ones if none |
| wr_en | input | 1 | Write a slot at the edge |
| wr_index | input | 5 | Slot index to write, may be out of range |
| wr_entry | input | 94 | Slot contents to write |
| wr_overflow | output | 1 | Current write index is out of range |
| rd_use_next | input | 1 | Read the slot under the next-to-use pointer |
| rd_index | input | 4 | Slot index to read when not using the pointer |
| rd_advance | input | 1 | Advance the next-to-use pointer at the edge |
| rd_slot | output | 4 | Index of the slot being read |
| rd_entry | output | 94 | Contents of the slot being read |

## Verification
A lookup and a write can fall in the same cycle and touch the same slot. The bench holds a lookup on a resident page while it rewrites that slot with a new frame. In that cycle it expects the old frame, and after the edge it expects the new one. A flush can coincide with a pending advance or write. The bench compares every output against a behavioural model on every falling edge, so a write or advance that leaks past a flush would show up as a read or pointer mismatch in the cycles that follow.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    parameter int VA_W       = 32;
    parameter int PAGE_SHIFT = 12;
    parameter int MASK_W     = 16;
    parameter int ASID_W     = 8;
    parameter int PFN_W      = 20;
    parameter int ATTR_W     = 3;
    localparam int VPN2_W    = VA_W - PAGE_SHIFT - 1;

    localparam logic [VA_W-1:0] UNCACHED_PATTERN = VA_W'(32'hA000_0000);

    typedef struct packed {
        logic [PFN_W-1:0]  pfn;
        logic [ATTR_W-1:0] attr;
        logic              dirty;
        logic              valid;
    } frame_t;

    typedef struct packed {
        logic [VPN2_W-1:0] tag;
        logic [MASK_W-1:0] mask;
        logic [ASID_W-1:0] asid;
        logic              global_map;
        frame_t            odd;
        frame_t            even;
    } entry_t;

    localparam int ENTRY_W = $bits(entry_t);

    // Pick odd half: the address bit just above the masked region.
    function automatic logic odd_half(input logic [MASK_W:0]   low_bits,
                                      input logic [MASK_W-1:0] mask);
        logic [MASK_W:0] ext;
        logic [MASK_W:0] first_zero;
        ext        = {1'b0, mask};
        first_zero = ~ext & (ext + (MASK_W+1)'(1));
        return |(low_bits & first_zero);
    endfunction
endpackage

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  logic [ENTRIES-1:0][VPN2_W-1:0] tags,
    input  logic [ENTRIES-1:0][MASK_W-1:0] masks,
    input  logic [ENTRIES-1:0][ASID_W-1:0] asids,
    input  logic [ENTRIES-1:0]             globals,
    input  logic [ENTRIES-1:0]             active,
    input  logic [VPN2_W-1:0]              req_vpn2,
    input  logic [ASID_W-1:0]              req_asid,
    output logic [ENTRIES-1:0]             hits
);
    timeunit 1ns; timeprecision 1ps;
    localparam int PAD = VPN2_W - MASK_W;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        logic [VPN2_W-1:0] care;
        logic              tag_ok;
        logic              space_ok;
        assign care     = ~{{PAD{1'b0}}, masks[i]};
        assign tag_ok   = ((req_vpn2 ^ tags[i]) & care) == '0;
        assign space_ok = globals[i] | (req_asid == asids[i]);
        assign hits[i]  = active[i] & tag_ok & space_ok;
    end
endmodule

// File: rtl/tlb_prio.sv
module tlb_prio #(
    parameter  int ENTRIES = 16,
    localparam int IDXW    = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] req,
    output logic               found,
    output logic [IDXW-1:0]    idx
);
    timeunit 1ns; timeprecision 1ps;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDXW'(i);
            end
        end
    end
endmodule

// File: rtl/tlb_store.sv
module tlb_store
    import tlb_pkg::*;
#(
    parameter  int ENTRIES = 16,
    localparam int IDXW    = $clog2(ENTRIES)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      flush,
    input  logic                      wr_en,
    input  logic [IDXW:0]             wr_index,
    input  entry_t                    wr_data,
    input  logic                      advance,
    output entry_t [ENTRIES-1:0]      slots,
    output logic   [IDXW-1:0]         next_use,
    output logic                      wr_reject
);
    timeunit 1ns; timeprecision 1ps;
    localparam logic [IDXW:0]   LIMIT = (IDXW+1)'(ENTRIES);
    localparam logic [IDXW-1:0] LAST  = IDXW'(ENTRIES - 1);

    logic in_range;
    assign in_range  = wr_index < LIMIT;
    assign wr_reject = wr_en & ~in_range;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            slots    <= '0;
            next_use <= '0;
        end else begin
            if (wr_en && in_range) begin
                slots[wr_index[IDXW-1:0]] <= wr_data;
            end
            if (advance) begin
                next_use <= (next_use == LAST) ? '0 : next_use + IDXW'(1);
            end
        end
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !flush && !in_range) |=> (slots == $past(slots)));

    assert_flush_clears_R7: assert property (@(posedge clk) disable iff (rst)
        flush |=> (next_use == '0 && slots == '0));

    assert_pointer_wrap_R9: assert property (@(posedge clk) disable iff (rst)
        (advance && !flush) |=>
        (next_use == (($past(next_use) == LAST) ? '0 : $past(next_use) + IDXW'(1))));
endmodule

// File: rtl/masked_tlb.sv
module masked_tlb
    import tlb_pkg::*;
#(
    parameter  int ENTRIES = 16,
    localparam int IDXW    = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               flush,
    input  logic [VA_W-1:0]    lk_vaddr,
    input  logic [ASID_W-1:0]  lk_asid,
    output logic               lk_hit,
    output logic               lk_invalid,
    output logic [IDXW-1:0]    lk_index,
    output logic [PFN_W-1:0]   lk_pfn,
    output logic [ATTR_W-1:0]  lk_attr,
    output logic               lk_dirty,
    output logic               lk_uncached,
    input  logic [VPN2_W-1:0]  pr_vpn2,
    input  logic [ASID_W-1:0]  pr_asid,
    output logic [IDXW:0]      pr_slot,
    input  logic               wr_en,
    input  logic [IDXW:0]      wr_index,
    input  logic [ENTRY_W-1:0] wr_entry,
    output logic               wr_overflow,
    input  logic               rd_use_next,
    input  logic [IDXW-1:0]    rd_index,
    input  logic               rd_advance,
    output logic [IDXW-1:0]    rd_slot,
    output logic [ENTRY_W-1:0] rd_entry
);
    timeunit 1ns; timeprecision 1ps;
    localparam logic [IDXW:0] LIMIT = (IDXW+1)'(ENTRIES);

    entry_t [ENTRIES-1:0] slots;
    logic   [IDXW-1:0]    next_use;

    tlb_store #(.ENTRIES(ENTRIES)) u_store (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .wr_en    (wr_en),
        .wr_index (wr_index),
        .wr_data  (entry_t'(wr_entry)),
        .advance  (rd_advance),
        .slots    (slots),
        .next_use (next_use),
        .wr_reject(wr_overflow)
    );

    // Field views for the comparators.
    logic [ENTRIES-1:0][VPN2_W-1:0] tags;
    logic [ENTRIES-1:0][MASK_W-1:0] masks;
    logic [ENTRIES-1:0][ASID_W-1:0] asids;
    logic [ENTRIES-1:0]             globals;
    logic [ENTRIES-1:0]             active;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_fields
        assign tags[i]    = slots[i].tag;
        assign masks[i]   = slots[i].mask;
        assign asids[i]   = slots[i].asid;
        assign globals[i] = slots[i].global_map;
        assign active[i]  = slots[i].even.valid | slots[i].odd.valid;
    end

    // Lookup path.
    logic [ENTRIES-1:0] lk_match;
    logic               lk_found;
    logic [IDXW-1:0]    lk_pick;
    entry_t             lk_entry;
    frame_t             lk_frame;

    tlb_match #(.ENTRIES(ENTRIES)) u_lk_match (
        .tags    (tags),
        .masks   (masks),
        .asids   (asids),
        .globals (globals),
        .active  (active),
        .req_vpn2(lk_vaddr[VA_W-1 -: VPN2_W]),
        .req_asid(lk_asid),
        .hits    (lk_match)
    );

    tlb_prio #(.ENTRIES(ENTRIES)) u_lk_prio (
        .req  (lk_match),
        .found(lk_found),
        .idx  (lk_pick)
    );

    always_comb begin
        lk_entry = slots[lk_pick];
        lk_frame = odd_half(lk_vaddr[PAGE_SHIFT +: MASK_W+1], lk_entry.mask)
                   ? lk_entry.odd : lk_entry.even;
        lk_hit     = lk_found & lk_frame.valid;
        lk_invalid = lk_found & ~lk_frame.valid;
        lk_index   = lk_pick;
        lk_pfn     = lk_hit ? lk_frame.pfn   : '0;
        lk_attr    = lk_hit ? lk_frame.attr  : '0;
        lk_dirty   = lk_hit & lk_frame.dirty;
    end

    assign lk_uncached = (lk_vaddr & UNCACHED_PATTERN) == UNCACHED_PATTERN;

    // Probe path.
    logic [ENTRIES-1:0] pr_match;
    logic               pr_found;
    logic [IDXW-1:0]    pr_pick;

    tlb_match #(.ENTRIES(ENTRIES)) u_pr_match (
        .tags    (tags),
        .masks   (masks),
        .asids   (asids),
        .globals (globals),
        .active  (active),
        .req_vpn2(pr_vpn2),
        .req_asid(pr_asid),
        .hits    (pr_match)
    );

    tlb_prio #(.ENTRIES(ENTRIES)) u_pr_prio (
        .req  (pr_match),
        .found(pr_found),
        .idx  (pr_pick)
    );

    assign pr_slot = pr_found ? {1'b0, pr_pick} : '1;

    // Read port.
    assign rd_slot  = rd_use_next ? next_use : rd_index;
    assign rd_entry = ({1'b0, rd_slot} < LIMIT) ? slots[rd_slot] : '0;

    assert_probe_code_R4: assert property (@(posedge clk) disable iff (rst)
        (pr_slot == '1) || (pr_slot < LIMIT));

    assert_probe_agrees_R6: assert property (@(posedge clk) disable iff (rst)
        (pr_vpn2 == lk_vaddr[VA_W-1 -: VPN2_W] && pr_asid == lk_asid &&
         (lk_hit || lk_invalid)) |-> (pr_slot == {1'b0, lk_index}));

    assert_invalid_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        lk_invalid |-> (!lk_hit && lk_pfn == '0 && !lk_dirty));
endmodule

// File: tb/masked_tlb_test.sv
module masked_tlb_test;
    timeunit 1ns; timeprecision 1ps;
    localparam int N = 16;

    logic        clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst, flush;
    logic [31:0] lk_vaddr;
    logic [7:0]  lk_asid;
    logic        lk_hit, lk_invalid, lk_dirty, lk_uncached;
    logic [3:0]  lk_index;
    logic [19:0] lk_pfn;
    logic [2:0]  lk_attr;
    logic [18:0] pr_vpn2;
    logic [7:0]  pr_asid;
    logic [4:0]  pr_slot;
    logic        wr_en, wr_overflow;
    logic [4:0]  wr_index;
    logic [93:0] wr_entry;
    logic        rd_use_next, rd_advance;
    logic [3:0]  rd_index, rd_slot;
    logic [93:0] rd_entry;

    masked_tlb #(.ENTRIES(N)) uut (
        .clk(clk), .rst(rst), .flush(flush),
        .lk_vaddr(lk_vaddr), .lk_asid(lk_asid), .lk_hit(lk_hit),
        .lk_invalid(lk_invalid), .lk_index(lk_index), .lk_pfn(lk_pfn),
        .lk_attr(lk_attr), .lk_dirty(lk_dirty), .lk_uncached(lk_uncached),
        .pr_vpn2(pr_vpn2), .pr_asid(pr_asid), .pr_slot(pr_slot),
        .wr_en(wr_en), .wr_index(wr_index), .wr_entry(wr_entry),
        .wr_overflow(wr_overflow), .rd_use_next(rd_use_next),
        .rd_index(rd_index), .rd_advance(rd_advance), .rd_slot(rd_slot),
        .rd_entry(rd_entry)
    );

    logic [93:0] mdl [N];
    int          mnlu;
    int          nchk = 0;
    int          nfail = 0;
    bit          done = 0;

    task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [93:0] mk(logic [18:0] tag, logic [15:0] mask,
            logic [7:0] asid, logic g, logic [19:0] p1, logic [2:0] a1,
            logic d1, logic v1, logic [19:0] p0, logic [2:0] a0, logic d0, logic v0);
        return {tag, mask, asid, g, p1, a1, d1, v1, p0, a0, d0, v0};
    endfunction

    function automatic bit m_match(logic [93:0] e, logic [18:0] v, logic [7:0] a);
        if (!(e[0] || e[25])) return 0;
        for (int b = 0; b < 19; b++) begin
            if (b < 16 && e[59+b]) continue;
            if (v[b] != e[75+b]) return 0;
        end
        return e[50] || (e[58:51] == a);
    endfunction

    function automatic int m_first(logic [18:0] v, logic [7:0] a);
        for (int i = 0; i < N; i++) if (m_match(mdl[i], v, a)) return i;
        return -1;
    endfunction

    // Reference state update.
    always @(posedge clk) begin
        if (rst || flush) begin
            for (int i = 0; i < N; i++) mdl[i] = '0;
            mnlu = 0;
        end else begin
            if (wr_en && wr_index < N) mdl[wr_index] = wr_entry;
            if (rd_advance) mnlu = (mnlu + 1) % N;
        end
    end

    // Whole-output comparison every cycle.
    always @(negedge clk) begin
        if (!rst && !done) begin
            int li, pi, p, slot;
            logic [93:0] e;
            logic [24:0] fr;
            logic eh, ei;
            li = m_first(lk_vaddr[31:13], lk_asid);
            eh = 0; ei = 0; fr = '0;
            if (li >= 0) begin
                e = mdl[li];
                p = 0;
                while (p < 16 && e[59+p]) p++;
                fr = lk_vaddr[12+p] ? e[49:25] : e[24:0];
                eh = fr[0];
                ei = !fr[0];
            end
            chk("R1 R2 R10 R11 lookup hit", lk_hit, eh);
            chk("R5 lookup invalid", lk_invalid, ei);
            chk("R6 lookup index", lk_index, (li >= 0) ? li : 0);
            chk("R5 lookup frame", {lk_pfn, lk_attr, lk_dirty},
                eh ? {fr[24:5], fr[4:2], fr[1]} : 24'h0);
            chk("R8 uncached", lk_uncached, lk_vaddr[31] && lk_vaddr[29]);
            pi = m_first(pr_vpn2, pr_asid);
            chk("R4 probe", pr_slot, (pi >= 0) ? pi : 5'h1F);
            chk("R3 overflow flag", wr_overflow, wr_en && wr_index >= N);
            slot = rd_use_next ? mnlu : rd_index;
            chk("R9 read slot", rd_slot, slot);
            chk("R9 read entry", rd_entry, mdl[slot]);
        end
    end

    task automatic edge_end();
        @(posedge clk);
        #1;
        wr_en = 0; flush = 0; rd_advance = 0;
    endtask

    task automatic put(int idx, logic [93:0] d);
        wr_en = 1; wr_index = 5'(idx); wr_entry = d;
        edge_end();
    endtask

    logic [93:0] e1, e2, e3, e5;

    initial begin
        rst = 1; flush = 0; lk_vaddr = 0; lk_asid = 0; pr_vpn2 = 0; pr_asid = 0;
        wr_en = 0; wr_index = 0; wr_entry = 0; rd_use_next = 0; rd_index = 0;
        rd_advance = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0;

        @(negedge clk);
        chk("R7 reset lookup", {lk_hit, lk_invalid}, 2'b00);
        chk("R7 reset probe", pr_slot, 5'h1F);
        chk("R7 reset read", rd_entry, 94'h0);
        edge_end();

        e2 = mk(19'h00012, 16'h0, 8'd5, 0, 20'h22222, 3'd1, 0, 0, 20'h11111, 3'd3, 1, 1);
        e5 = mk(19'h00400, 16'h000F, 8'd9, 1, 20'h55551, 3'd2, 0, 1, 20'h55550, 3'd5, 0, 1);
        e1 = mk(19'h00400, 16'h000F, 8'd9, 0, 20'h77771, 3'd6, 1, 1, 20'h77770, 3'd4, 0, 1);
        e3 = mk(19'h00077, 16'h0, 8'd5, 0, 20'h12345, 3'd1, 0, 0, 20'h54321, 3'd1, 0, 0);
        put(2, e2); put(5, e5); put(1, e1); put(3, e3);

        lk_vaddr = 32'h0002_4000; lk_asid = 8'd5;
        @(negedge clk);
        chk("R1 even hit", {lk_hit, lk_index, lk_pfn, lk_attr, lk_dirty},
            {1'b1, 4'd2, 20'h11111, 3'd3, 1'b1});
        edge_end();
        lk_vaddr = 32'h0002_5000;
        @(negedge clk);
        chk("R5 invalid odd frame", {lk_hit, lk_invalid, lk_pfn}, {1'b0, 1'b1, 20'h0});
        edge_end();
        lk_vaddr = 32'h0002_4000; lk_asid = 8'd6;
        @(negedge clk);
        chk("R2 identifier mismatch", {lk_hit, lk_invalid}, 2'b00);
        edge_end();

        lk_vaddr = 32'h0081_4000; lk_asid = 8'd1;
        @(negedge clk);
        chk("R1 R2 masked global odd", {lk_hit, lk_index, lk_pfn}, {1'b1, 4'd5, 20'h55551});
        edge_end();
        lk_vaddr = 32'h0080_4000;
        @(negedge clk);
        chk("R5 masked even", {lk_hit, lk_pfn}, {1'b1, 20'h55550});
        edge_end();
        lk_vaddr = 32'h0082_0000;
        @(negedge clk);
        chk("R1 unmasked bit differs", lk_hit, 1'b0);
        edge_end();
        lk_vaddr = 32'h0081_4000; lk_asid = 8'd9;
        pr_vpn2 = 19'h0040A; pr_asid = 8'd9;
        @(negedge clk);
        chk("R6 lowest index wins", {lk_index, lk_pfn}, {4'd1, 20'h77771});
        chk("R4 probe first match", pr_slot, 5'd1);
        edge_end();
        pr_vpn2 = 19'h00410;
        @(negedge clk);
        chk("R4 probe not found", pr_slot, 5'h1F);
        edge_end();

        lk_vaddr = 32'h000E_E000; lk_asid = 8'd5; pr_vpn2 = 19'h00077; pr_asid = 8'd5;
        @(negedge clk);
        chk("R11 inactive slot lookup", {lk_hit, lk_invalid}, 2'b00);
        chk("R11 inactive slot probe", pr_slot, 5'h1F);
        edge_end();

        wr_en = 1; wr_index = 5'd16;
        wr_entry = mk(19'h0, 16'h0, 8'd0, 1, 20'h0, 3'd0, 0, 0, 20'hABCDE, 3'd0, 0, 1);
        @(negedge clk);
        chk("R3 overflow flag", wr_overflow, 1'b1);
        edge_end();
        rd_index = 4'd0;
        @(negedge clk);
        chk("R3 table unchanged", rd_entry, 94'h0);
        chk("R3 no flag idle", wr_overflow, 1'b0);
        edge_end();

        lk_vaddr = 32'h0002_4000; lk_asid = 8'd5;
        wr_en = 1; wr_index = 5'd2;
        wr_entry = mk(19'h00012, 16'h0, 8'd5, 0, 20'h0, 3'd0, 0, 0, 20'h33333, 3'd3, 1, 1);
        @(negedge clk);
        chk("R10 old contents during write", lk_pfn, 20'h11111);
        edge_end();
        @(negedge clk);
        chk("R10 new contents after edge", lk_pfn, 20'h33333);
        edge_end();

        lk_vaddr = 32'hA000_1000;
        @(negedge clk);
        chk("R8 uncached pattern", lk_uncached, 1'b1);
        edge_end();
        lk_vaddr = 32'h8000_0000;
        @(negedge clk);
        chk("R8 partial pattern", lk_uncached, 1'b0);
        edge_end();

        rd_use_next = 1;
        @(negedge clk);
        chk("R9 pointer at zero", rd_slot, 4'd0);
        edge_end();
        rd_advance = 1;
        edge_end();
        @(negedge clk);
        chk("R9 pointer read slot one", rd_entry, e1);
        edge_end();
        for (int k = 0; k < 15; k++) begin
            rd_advance = 1;
            edge_end();
        end
        @(negedge clk);
        chk("R9 pointer wrapped", rd_slot, 4'd0);
        edge_end();
        rd_advance = 1;
        edge_end();

        flush = 1; rd_advance = 1; wr_en = 1; wr_index = 5'd4; wr_entry = e5;
        edge_end();
        lk_vaddr = 32'h0081_4000; lk_asid = 8'd1;
        @(negedge clk);
        chk("R7 flush pointer", rd_slot, 4'd0);
        chk("R7 flush lookup", lk_hit, 1'b0);
        edge_end();
        rd_use_next = 0; rd_index = 4'd4;
        @(negedge clk);
        chk("R7 flush beats write", rd_entry, 94'h0);
        edge_end();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            nfail++;
            $display("FAIL watchdog all requirements actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end
endmodule